// File: doc/BRIEF.md
# Shared Memory Port Cycle Sequencer

This block decides what a single memory port does on each transaction of a small pipelined processor. A port transaction is one of three kinds: an instruction fetch, a DMA read that serves a periodic refresh engine, or the data access of a load or store that sits in the execute stage. One pipeline cycle always starts with a fetch. A pending DMA read may follow it, and then the execute-stage load or store may follow. The sequencer moves to the next transaction only when memory reports completion. While memory is not ready it holds the whole pipeline.

For each transaction the block tells the address path and the memory controller whether a new transaction may start, and it gives the direction, width and data-bus use of that transaction. It also drives the pipeline-wide clock enable. When a DMA read or a load/store follows a fetch, the port is busy at the point where the instruction register would normally load from it. The fetched word is therefore kept in a holding register, and the instruction register is later fed from that register. This lets a load or store with no wait states take two pipeline clocks instead of three.

Top module: `mem_cycle_seq`

## Requirements
- R1: After reset the current transaction kind `mem_kind` is fetch (encoding 0 = fetch, 1 = DMA, 2 = load/store). No DMA request is pending and the holding register is not selected.
- R2: `mem_kind` changes only on a clock edge where `mem_rdy` is 1. While `mem_rdy` is 0, `pipe_ce` and `hold_cap` are 0.
- R3: `addr_ce` is 1 exactly in the cycles where `mem_rdy` is 1.
- R4: When a fetch completes, the next transaction is DMA if a request is pending. Otherwise it is load/store if a live execute-stage load/store exists (`ex_ls`=1, `ex_annul`=0). Otherwise it is a fetch. When a DMA read completes, the next transaction is load/store if one is live, and fetch otherwise. When a load/store completes, the next transaction is always a fetch.
- R5: `pipe_ce` is 1 exactly when `mem_rdy` is 1 and the next transaction chosen under R4 is a fetch.
- R6: `hold_cap` is 1 when a fetch completes and the next transaction is not a fetch. On that edge the holding register loads `mem_rdata`. `ir_src_hold` is 1 from that edge until the edge after the next `pipe_ce`. `ir_word` carries the held word while `ir_src_hold` is 1, and `mem_rdata` otherwise.
- R7: The qualifiers describe the transaction chosen under R4. `nxt_dbus` is 1 only for load/store. `nxt_read` is 0 only for a load/store with `ex_store`=1. `nxt_word` is 0 only for a load/store with `ex_byte`=1.
- R8: When `ex_annul` is 1, `ex_ls` has no effect: no load/store transaction is chosen and `nxt_dbus` stays 0.
- R9: A `dma_req` pulse makes a DMA request pending from the next edge. The request is cleared when a DMA transaction completes. A request seen in the same cycle as that completion stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdy | input | 1 | Current memory transaction completes this cycle |
| dma_req | input | 1 | DMA read request pulse |
| ex_ls | input | 1 | Execute-stage instruction is a load or store |
| ex_store | input | 1 | Execute-stage access is a store |
| ex_byte | input | 1 | Execute-stage access is a byte access |
| ex_annul | input | 1 | Execute-stage instruction is annulled |
| mem_rdata | input | INSN_W | Word returned by the memory port |
| addr_ce | output | 1 | Start a new transaction next cycle |
| nxt_read | output | 1 | Next transaction is a read |
| nxt_word | output | 1 | Next transaction is full-word |
| nxt_dbus | output | 1 | Next transaction uses the data bus (load/store) |
| pipe_ce | output | 1 | Pipeline clock enable |
| hold_cap | output | 1 | Capture strobe of the holding register |
| ir_src_hold | output | 1 | Instruction register loads from the holding register |
| ir_word | output | INSN_W | Word offered to the instruction register |
| mem_kind | output | 2 | Kind of the transaction in progress |

## Verification
The bound checker checks the following on every cycle: the kind is frozen while memory is not ready, `pipe_ce` and `hold_cap` occur only on completion, and a transaction flagged for the data bus is followed by the load/store state. It also checks that a DMA or load/store transaction never repeats back to back, that a write qualifier implies data-bus use, and that a request always leaves a pending DMA. The fixed fetch–DMA–load/store order inside one pipeline cycle can only be shown by the bench's scenarios. The same holds for a request that coincides with a DMA completion, the suppression of annulled accesses, and the word delivered from the holding register. The bench compares these against a reference model driven by random ready, request and execute-stage patterns.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    // Kind of the memory transaction in progress on the shared port
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_DMA   = 2'd1,
        KIND_LS    = 2'd2
    } mem_kind_e;

    // Registered state of the sequencer
    typedef struct packed {
        mem_kind_e kind;
        logic      dma_pend;
        logic      hold_vld;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{kind: KIND_FETCH, dma_pend: 1'b0, hold_vld: 1'b0};

endpackage

// File: rtl/mcs_arbiter.sv
module mcs_arbiter
    import mcs_pkg::*;
(
    input  mem_kind_e cur_kind,
    input  logic      dma_pend,
    input  logic      ls_live,
    input  logic      mem_rdy,
    output mem_kind_e nxt_kind,
    output logic      pipe_last,
    output logic      dma_done
);

    // Order within one pipeline cycle: fetch, optional DMA, optional load/store
    always_comb begin
        nxt_kind = cur_kind;
        if (mem_rdy) begin
            unique case (cur_kind)
                KIND_FETCH: begin
                    if (dma_pend)     nxt_kind = KIND_DMA;
                    else if (ls_live) nxt_kind = KIND_LS;
                    else              nxt_kind = KIND_FETCH;
                end
                KIND_DMA:   nxt_kind = ls_live ? KIND_LS : KIND_FETCH;
                KIND_LS:    nxt_kind = KIND_FETCH;
                default:    nxt_kind = KIND_FETCH;
            endcase
        end
    end

    // The pipeline advances when the last transaction of its cycle completes
    assign pipe_last = mem_rdy && (nxt_kind == KIND_FETCH);
    assign dma_done  = mem_rdy && (cur_kind == KIND_DMA);

endmodule

// File: rtl/mcs_qual.sv
module mcs_qual
    import mcs_pkg::*;
(
    input  mem_kind_e nxt_kind,
    input  logic      ex_store,
    input  logic      ex_byte,
    output logic      nxt_read,
    output logic      nxt_word,
    output logic      nxt_dbus
);

    logic is_ls;

    always_comb begin
        is_ls    = (nxt_kind == KIND_LS);
        nxt_dbus = is_ls;
        nxt_read = !(is_ls && ex_store);
        nxt_word = !(is_ls && ex_byte);
    end

endmodule

// File: rtl/mcs_hold.sv
module mcs_hold #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (cap) word_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign dout = word_q;

endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq #(
    parameter int unsigned INSN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rdy,
    input  logic              dma_req,
    input  logic              ex_ls,
    input  logic              ex_store,
    input  logic              ex_byte,
    input  logic              ex_annul,
    input  logic [INSN_W-1:0] mem_rdata,
    output logic              addr_ce,
    output logic              nxt_read,
    output logic              nxt_word,
    output logic              nxt_dbus,
    output logic              pipe_ce,
    output logic              hold_cap,
    output logic              ir_src_hold,
    output logic [INSN_W-1:0] ir_word,
    output logic [1:0]        mem_kind
);
    import mcs_pkg::*;

    seq_state_t        state_d, state_q;
    mem_kind_e         kind_nx;
    logic              pipe_last;
    logic              dma_done;
    logic              ls_live;
    logic              cap;
    logic              pend_q;
    logic [INSN_W-1:0] hold_q;

    // An annulled execute-stage access never reaches the port
    assign ls_live = ex_ls & ~ex_annul;

    mcs_arbiter u_arb (
        .cur_kind (state_q.kind),
        .dma_pend (state_q.dma_pend),
        .ls_live  (ls_live),
        .mem_rdy  (mem_rdy),
        .nxt_kind (kind_nx),
        .pipe_last(pipe_last),
        .dma_done (dma_done)
    );

    mcs_qual u_qual (
        .nxt_kind(kind_nx),
        .ex_store(ex_store),
        .ex_byte (ex_byte),
        .nxt_read(nxt_read),
        .nxt_word(nxt_word),
        .nxt_dbus(nxt_dbus)
    );

    // Early-fetched word is parked when the port is needed again this pipeline cycle
    assign cap = mem_rdy && (state_q.kind == KIND_FETCH) && (kind_nx != KIND_FETCH);

    mcs_hold #(.W(INSN_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cap),
        .din  (mem_rdata),
        .dout (hold_q)
    );

    always_comb begin
        state_d          = state_q;
        state_d.kind     = kind_nx;
        state_d.dma_pend = (state_q.dma_pend & ~dma_done) | dma_req;
        if (cap)            state_d.hold_vld = 1'b1;
        else if (pipe_last) state_d.hold_vld = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_RESET;
        else        state_q <= state_d;
    end

    assign addr_ce     = mem_rdy;
    assign pipe_ce     = pipe_last;
    assign hold_cap    = cap;
    assign ir_src_hold = state_q.hold_vld;
    assign ir_word     = state_q.hold_vld ? hold_q : mem_rdata;
    assign mem_kind    = state_q.kind;
    assign pend_q      = state_q.dma_pend;

endmodule

// File: rtl/mcs_chk.sv
module mcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_rdy,
    input logic       dma_req,
    input logic       nxt_read,
    input logic       nxt_dbus,
    input logic       pipe_ce,
    input logic       hold_cap,
    input logic [1:0] mem_kind,
    input logic       dma_pend
);

    // R2
    kind_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rdy |=> $stable(mem_kind));

    // R2
    pipe_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_ce |-> mem_rdy);

    // R6
    cap_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cap |-> (mem_rdy && mem_kind == 2'd0 && !pipe_ce));

    // R7
    dbus_leads_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rdy && nxt_dbus) |=> (mem_kind == 2'd2));

    // R7
    write_uses_dbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nxt_read |-> nxt_dbus);

    // R4
    no_dma_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rdy && mem_kind == 2'd1) |=> (mem_kind != 2'd1));

    // R4
    ls_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rdy && mem_kind == 2'd2) |=> (mem_kind == 2'd0));

    // R9
    req_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> dma_pend);

endmodule

bind mem_cycle_seq mcs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_rdy (mem_rdy),
    .dma_req (dma_req),
    .nxt_read(nxt_read),
    .nxt_dbus(nxt_dbus),
    .pipe_ce (pipe_ce),
    .hold_cap(hold_cap),
    .mem_kind(mem_kind),
    .dma_pend(pend_q)
);

// File: tb/mem_cycle_seq_bench.sv
module mem_cycle_seq_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mem_rdy = 1'b0, dma_req = 1'b0;
    logic         ex_ls = 1'b0, ex_store = 1'b0, ex_byte = 1'b0, ex_annul = 1'b0;
    logic [W-1:0] mem_rdata = '0;
    logic         addr_ce, nxt_read, nxt_word, nxt_dbus, pipe_ce, hold_cap, ir_src_hold;
    logic [W-1:0] ir_word;
    logic [1:0]   mem_kind;

    int checks = 0;
    int errors = 0;

    // 200 MHz: 2500 ps half period
    always #2500 clk = ~clk;

    mem_cycle_seq #(.INSN_W(W)) u_mem_cycle_seq (
        .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .dma_req(dma_req),
        .ex_ls(ex_ls), .ex_store(ex_store), .ex_byte(ex_byte), .ex_annul(ex_annul),
        .mem_rdata(mem_rdata), .addr_ce(addr_ce), .nxt_read(nxt_read),
        .nxt_word(nxt_word), .nxt_dbus(nxt_dbus), .pipe_ce(pipe_ce),
        .hold_cap(hold_cap), .ir_src_hold(ir_src_hold), .ir_word(ir_word),
        .mem_kind(mem_kind)
    );

    // Reference model state
    logic [1:0]   m_kind = 2'd0;
    logic         m_pend = 1'b0;
    logic         m_hvld = 1'b0;
    logic [W-1:0] m_hold = '0;
    logic         last_pipe = 1'b1;

    function automatic logic [1:0] ref_next(input logic [1:0] k, input logic pend,
                                            input logic live, input logic rdy);
        if (!rdy) return k;
        case (k)
            2'd0:    return pend ? 2'd1 : (live ? 2'd2 : 2'd0);
            2'd1:    return live ? 2'd2 : 2'd0;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one clock of stimulus, check every output against the model, advance the model
    task automatic cyc(input logic rdy, input logic dreq, input logic ls, input logic st,
                       input logic byt, input logic ann, input logic [W-1:0] rd);
        logic [1:0] nk;
        logic e_pipe, e_cap, e_live;
        @(negedge clk);
        mem_rdy = rdy; dma_req = dreq; ex_ls = ls; ex_store = st;
        ex_byte = byt; ex_annul = ann; mem_rdata = rd;
        #1;
        e_live = ls & ~ann;
        nk     = ref_next(m_kind, m_pend, e_live, rdy);
        e_pipe = rdy && (nk == 2'd0);
        e_cap  = rdy && (m_kind == 2'd0) && (nk != 2'd0);
        chk("R4 mem_kind", {14'd0, mem_kind}, {14'd0, m_kind});
        chk("R3 addr_ce", {15'd0, addr_ce}, {15'd0, rdy});
        chk("R5 pipe_ce", {15'd0, pipe_ce}, {15'd0, e_pipe});
        chk("R6 hold_cap", {15'd0, hold_cap}, {15'd0, e_cap});
        chk("R6 ir_src_hold", {15'd0, ir_src_hold}, {15'd0, m_hvld});
        chk("R6 ir_word", ir_word, m_hvld ? m_hold : rd);
        chk("R7 nxt_dbus", {15'd0, nxt_dbus}, {15'd0, nk == 2'd2});
        chk("R7 nxt_read", {15'd0, nxt_read}, {15'd0, !(nk == 2'd2 && st)});
        chk("R7 nxt_word", {15'd0, nxt_word}, {15'd0, !(nk == 2'd2 && byt)});
        @(posedge clk);
        if (e_cap) begin m_hold = rd; m_hvld = 1'b1; end
        else if (e_pipe) m_hvld = 1'b0;
        m_pend    = (m_pend & ~(rdy && m_kind == 2'd1)) | dreq;
        m_kind    = nk;
        last_pipe = e_pipe;
    endtask

    task automatic expect_kind(input logic [1:0] k, input string tag);
        #1;
        chk(tag, {14'd0, mem_kind}, {14'd0, k});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic s_ls, s_st, s_byt, s_ann;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mem_rdy = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset kind", {14'd0, mem_kind}, 16'd0);
        chk("R1 reset hold select", {15'd0, ir_src_hold}, 16'd0);
        chk("R1 reset no dbus", {15'd0, nxt_dbus}, 16'd0);
        chk("R1 reset pipe_ce", {15'd0, pipe_ce}, 16'd1);

        // R4/R9: queue a DMA, then fetch -> DMA -> LS; a request during DMA completion persists
        cyc(1, 1, 0, 0, 0, 0, 16'h1111); expect_kind(2'd0, "R4 plain fetch");
        cyc(1, 0, 1, 1, 0, 0, 16'h2222); expect_kind(2'd1, "R4 DMA follows fetch");
        cyc(1, 1, 1, 1, 0, 0, 16'h3333); expect_kind(2'd2, "R4 LS follows DMA");
        chk("R6 held word", ir_word, 16'h2222);
        cyc(1, 0, 1, 1, 0, 0, 16'h4444); expect_kind(2'd0, "R4 fetch follows LS");
        cyc(1, 0, 0, 0, 0, 0, 16'h5555); expect_kind(2'd1, "R9 request kept at clear");
        cyc(1, 0, 0, 0, 0, 0, 16'h6666); expect_kind(2'd0, "R9 DMA then fetch");

        // R2: stall inside a load/store cycle
        cyc(1, 0, 1, 0, 1, 0, 16'h7777); expect_kind(2'd2, "R2 enter LS");
        cyc(0, 0, 1, 0, 1, 0, 16'h8888); expect_kind(2'd2, "R2 stalled LS");
        cyc(0, 0, 1, 0, 1, 0, 16'h9999); expect_kind(2'd2, "R2 still stalled");
        chk("R2 pipe_ce low in stall", {15'd0, pipe_ce}, 16'd0);
        cyc(1, 0, 1, 0, 1, 0, 16'haaaa); expect_kind(2'd0, "R2 resume to fetch");

        // R8: annulled load/store is ignored
        cyc(1, 0, 1, 1, 1, 1, 16'hbbbb); expect_kind(2'd0, "R8 annulled stays fetch");
        chk("R8 no dbus", {15'd0, nxt_dbus}, 16'd0);

        // Random mix: execute-stage flags change only when the pipeline advanced
        s_ls = 0; s_st = 0; s_byt = 0; s_ann = 0;
        for (int i = 0; i < 3000; i++) begin
            if (last_pipe) begin
                s_ls  = ($urandom % 3) == 0;
                s_st  = $urandom % 2;
                s_byt = $urandom % 2;
                s_ann = ($urandom % 5) == 0;
            end
            cyc(($urandom % 4) != 0, ($urandom % 8) == 0, s_ls, s_st, s_byt, s_ann,
                16'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule